// File: doc/BRIEF.md
# Multiplexed-Address DRAM Cycle Decoder with Parallel Test Mode

This block is the device-side control of a one-bit-wide dynamic memory whose row and column addresses share one bus. It samples the active-low row strobe, column strobe and write enable on a system clock. At each row-strobe fall it classifies the cycle: a normal access (read or early write), a refresh that takes its row from the pins (row-strobe-only), a refresh that takes its row from an internal counter (column-before-row), or a column-before-row cycle with write enable low, which also switches on a compressed test mode. The cells form a behavioural array. The row and column registers are full width. The cell store is kept shallow by a parameter, so only selected address bits pick a distinct cell.

Cell index bits are, from most to least significant: row bit 10, column bit 10, column bit 0, row bits [ROW_KEEP-1:0], column bits [COL_KEEP-1:1]. Addresses that differ only in other bits alias to the same cell. In test mode the three upper index bits are don't-care, so every access covers eight cells. The data output has an enable that models a three-state pin. Read data stays driven after the column strobe rises (extended data out). The enable drops once both strobes are high, or when write enable falls.

The controller states are:
- ST_IDLE: row strobe high, no column held low.
- ST_ROW: row open, no column yet.
- ST_COL: column strobe low, access made.
- ST_PAGE: column strobe high again, row still open.
- ST_REF: counter refresh in progress.
- ST_CASLOW: row strobe high while the column strobe is still low.

The transitions are:
- IDLE→ROW: row strobe falls with column strobe high.
- IDLE/CASLOW→REF: row strobe falls with column strobe low.
- CASLOW→ROW: row strobe falls as the column strobe rises.
- ROW/PAGE→COL: column strobe falls.
- COL→PAGE: column strobe rises.
- ROW→IDLE: row strobe rises with no column access, which is a row-only refresh.
- COL/PAGE/REF→IDLE: row strobe rises with the column strobe high.
- COL/PAGE/REF→CASLOW: row strobe rises with the column strobe low.
- CASLOW→IDLE: column strobe rises.

Top module: `dram_cycle_ctrl`

## Requirements
- R1: After reset, dout_en, test_active and ref_busy are 0, ref_row is 0, and every cell reads 0.
- R2: A row-strobe fall with the column strobe high latches addr as the row. A later column-strobe fall with we_n high latches addr as the column, and dout carries that cell with dout_en=1 from the next cycle.
- R3: If we_n is low when the column strobe falls, din is stored in the addressed cell and dout_en stays 0 for the whole cycle.
- R4: While the row strobe stays low, dout_en and dout hold after the column strobe rises. A further column-strobe fall reads the new column.
- R5: dout_en goes to 0 in the cycle after both strobes are sampled high, and in the cycle after a fall of we_n.
- R6: A row-strobe fall with the column strobe low and we_n high sets ref_busy from the next cycle. ref_row then shows the internal counter and ignores addr.
- R7: The internal counter (10 bits) advances by one at the end of each counter refresh and wraps from 1023 to 0.
- R8: A row-strobe fall with both the column strobe and we_n low starts a counter refresh and sets test_active.
- R9: In test mode an early write stores din into all eight cells that differ only in row bit 10, column bit 10 and column bit 0.
- R10: In test mode a read drives dout=1 when the eight cells are equal and dout=0 when any differ.
- R11: A counter refresh with we_n high, or a row-strobe-only cycle, clears test_active.
- R12: Holding the column strobe low while the row strobe rises and falls again (hidden refresh) keeps the read data driven through the refresh.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ras_n | input | 1 | Row strobe, active low |
| cas_n | input | 1 | Column strobe, active low |
| we_n | input | 1 | Write enable, active low |
| addr | input | ADDR_W | Multiplexed row/column address |
| din | input | 1 | Write data |
| dout | output | 1 | Read data or test compare result |
| dout_en | output | 1 | Output drive enable (0 = high impedance) |
| test_active | output | 1 | Compressed test mode is on |
| ref_busy | output | 1 | Counter refresh in progress |
| ref_row | output | REF_W | Row taken from the counter by the latest counter refresh |

## Verification
The hardest states to reach are the counter wrap and the test-mode mismatch. The wrap only shows after a thousand counter refreshes, so the bench issues refreshes until its own count model reaches 1023. It then checks the next two reported rows. A mismatch in test mode needs one cell of a group to differ from the other seven, which test mode itself can never write. The bench therefore leaves test mode with a row-strobe-only cycle, writes a single cell normally, and re-enters test mode before reading. Hidden refresh is reached by holding the column strobe low across a full row-strobe pulse after a read.

// File: rtl/dram_pkg.sv
package dram_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ROW,
        ST_COL,
        ST_PAGE,
        ST_REF,
        ST_CASLOW
    } cyc_state_t;
endpackage

// File: rtl/dram_rfsh_ctr.sv
module dram_rfsh_ctr #(
    parameter int W = 10
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         step,
    output logic [W-1:0] count
);
    localparam logic [W-1:0] LAST = '1;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            count <= '0;
        end else if (step) begin
            count <= (count == LAST) ? '0 : count + 1'b1;
        end
    end
endmodule

// File: rtl/dram_cell_array.sv
module dram_cell_array #(
    parameter int ROW_W    = 11,
    parameter int COL_W    = 11,
    parameter int ROW_KEEP = 2,
    parameter int COL_KEEP = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [ROW_W-1:0] row,
    input  logic [COL_W-1:0] col,
    input  logic             wr_en,
    input  logic             grp_mode,
    input  logic             din,
    output logic             rd_bit,
    output logic             grp_match
);
    localparam int GRP   = 8;
    localparam int LOW_W = ROW_KEEP + COL_KEEP - 1;
    localparam int IDX_W = 3 + LOW_W;
    localparam int DEPTH = GRP << LOW_W;

    logic [DEPTH-1:0] mem;
    logic [LOW_W-1:0] low;
    logic [2:0]       sel;
    logic [GRP-1:0]   grp_bits;

    assign low = {row[ROW_KEEP-1:0], col[COL_KEEP-1:1]};
    assign sel = {row[ROW_W-1], col[COL_W-1], col[0]};

    assign rd_bit = mem[IDX_W'({sel, low})];

    for (genvar g = 0; g < GRP; g++) begin : g_grp
        localparam logic [2:0] GV = 3'(g);
        assign grp_bits[g] = mem[IDX_W'({GV, low})];
    end

    assign grp_match = (&grp_bits) | ~(|grp_bits);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mem <= '0;
        end else if (wr_en) begin
            for (int g = 0; g < GRP; g++) begin
                if (grp_mode || (sel == 3'(g))) begin
                    mem[IDX_W'({3'(g), low})] <= din;
                end
            end
        end
    end
endmodule

// File: rtl/dram_cycle_ctrl.sv
module dram_cycle_ctrl
    import dram_pkg::*;
#(
    parameter int ADDR_W   = 11,
    parameter int REF_W    = 10,
    parameter int ROW_KEEP = 2,
    parameter int COL_KEEP = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ras_n,
    input  logic              cas_n,
    input  logic              we_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic              din,
    output logic              dout,
    output logic              dout_en,
    output logic              test_active,
    output logic [REF_W-1:0]  ref_row,
    output logic              ref_busy
);
    cyc_state_t state, nxt;

    logic r_ras, r_cas, r_we;
    logic ras_fall, ras_rise, cas_fall, cas_rise, we_fall;
    logic start_row, start_ref, start_test;
    logic col_access, col_read, col_write;
    logic ras_only_end, ref_end;
    logic [ADDR_W-1:0] row_q;
    logic [REF_W-1:0]  ctr_val;
    logic              test_q;
    logic              arr_bit, arr_match;

    // strobe history for edge detection
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_ras <= 1'b1;
            r_cas <= 1'b1;
            r_we  <= 1'b1;
        end else begin
            r_ras <= ras_n;
            r_cas <= cas_n;
            r_we  <= we_n;
        end
    end

    assign ras_fall = r_ras & ~ras_n;
    assign ras_rise = ~r_ras & ras_n;
    assign cas_fall = r_cas & ~cas_n;
    assign cas_rise = ~r_cas & cas_n;
    assign we_fall  = r_we & ~we_n;

    // cycle classification at the row strobe fall
    assign start_row  = ras_fall & cas_n;
    assign start_ref  = ras_fall & ~cas_n;
    assign start_test = start_ref & ~we_n;

    assign col_access   = cas_fall & ~ras_n & ((state == ST_ROW) || (state == ST_PAGE));
    assign col_read     = col_access & we_n;
    assign col_write    = col_access & ~we_n;
    assign ras_only_end = (state == ST_ROW) & ras_rise;
    assign ref_end      = (state == ST_REF) & ras_rise;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_IDLE;
        end else begin
            state <= nxt;
        end
    end

    // next-state logic
    always_comb begin
        nxt = state;
        unique case (state)
            ST_IDLE: begin
                if (ras_fall) nxt = cas_n ? ST_ROW : ST_REF;
            end
            ST_ROW: begin
                if (ras_rise)      nxt = ST_IDLE;
                else if (cas_fall) nxt = ST_COL;
            end
            ST_COL: begin
                if (ras_rise)      nxt = cas_n ? ST_IDLE : ST_CASLOW;
                else if (cas_rise) nxt = ST_PAGE;
            end
            ST_PAGE: begin
                if (ras_rise)      nxt = cas_n ? ST_IDLE : ST_CASLOW;
                else if (cas_fall) nxt = ST_COL;
            end
            ST_REF: begin
                if (ras_rise) nxt = cas_n ? ST_IDLE : ST_CASLOW;
            end
            ST_CASLOW: begin
                if (ras_fall)   nxt = cas_n ? ST_ROW : ST_REF;
                else if (cas_n) nxt = ST_IDLE;
            end
            default: nxt = ST_IDLE;
        endcase
    end

    // registered outputs and latches
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            row_q   <= '0;
            ref_row <= '0;
            test_q  <= 1'b0;
            dout    <= 1'b0;
            dout_en <= 1'b0;
        end else begin
            if (start_row) row_q <= addr;
            if (start_ref) ref_row <= ctr_val;

            if (start_test)                     test_q <= 1'b1;
            else if (start_ref || ras_only_end) test_q <= 1'b0;

            if (col_read) begin
                dout_en <= 1'b1;
                dout    <= test_q ? arr_match : arr_bit;
            end else if ((ras_n && cas_n) || we_fall || (cas_fall && !we_n)) begin
                dout_en <= 1'b0;
            end
        end
    end

    assign test_active = test_q;
    assign ref_busy    = (state == ST_REF);

    dram_rfsh_ctr #(
        .W(REF_W)
    ) u_ctr (
        .clk   (clk),
        .rst_n (rst_n),
        .step  (ref_end),
        .count (ctr_val)
    );

    dram_cell_array #(
        .ROW_W   (ADDR_W),
        .COL_W   (ADDR_W),
        .ROW_KEEP(ROW_KEEP),
        .COL_KEEP(COL_KEEP)
    ) u_arr (
        .clk      (clk),
        .rst_n    (rst_n),
        .row      (row_q),
        .col      (addr),
        .wr_en    (col_write),
        .grp_mode (test_q),
        .din      (din),
        .rd_bit   (arr_bit),
        .grp_match(arr_match)
    );
endmodule

// File: rtl/dram_cycle_chk.sv
module dram_cycle_chk #(
    parameter int REF_W = 10
) (
    input logic             clk,
    input logic             rst_n,
    input logic             ras_n,
    input logic             cas_n,
    input logic             we_n,
    input logic             dout_en,
    input logic             test_active,
    input logic             ref_busy,
    input logic [REF_W-1:0] ref_row
);
    logic seen_ref;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) seen_ref <= 1'b0;
        else        seen_ref <= seen_ref | ref_busy;
    end

    AST_EARLY_WR_HIZ: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(cas_n) && !ras_n && !we_n) |=> !dout_en); // R3

    AST_OFF_BOTH_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        (ras_n && cas_n) |=> !dout_en); // R5

    AST_OFF_WE_FALL: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(we_n) |=> !dout_en); // R5

    AST_REF_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(ras_n) && !cas_n) |=> ref_busy); // R6

    AST_REF_ROW_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(ref_busy) && seen_ref) |-> (ref_row == REF_W'($past(ref_row) + 1'b1))); // R7

    AST_TEST_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(ras_n) && !cas_n && !we_n) |=> test_active); // R8

    AST_TEST_EXIT_CBR: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(ras_n) && !cas_n && we_n) |=> !test_active); // R11
endmodule

bind dram_cycle_ctrl dram_cycle_chk #(
    .REF_W(REF_W)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .ras_n      (ras_n),
    .cas_n      (cas_n),
    .we_n       (we_n),
    .dout_en    (dout_en),
    .test_active(test_active),
    .ref_busy   (ref_busy),
    .ref_row    (ref_row)
);

// File: tb/dram_cycle_ctrl_test.sv
module dram_cycle_ctrl_test;
    localparam int CLK_PERIOD = 10;
    localparam int NV = 9;

    typedef struct packed {
        logic        is_wr;
        logic [10:0] row;
        logic [10:0] col;
        logic        d;
    } vec_t;

    // R2/R3 normal writes and reads on distinct cells; last entry is an unwritten cell (R1)
    localparam vec_t VECS [NV] = '{
        '{1'b1, 11'h001, 11'h002, 1'b1},
        '{1'b1, 11'h002, 11'h002, 1'b0},
        '{1'b1, 11'h400, 11'h005, 1'b1},
        '{1'b1, 11'h003, 11'h401, 1'b1},
        '{1'b0, 11'h001, 11'h002, 1'b1},
        '{1'b0, 11'h002, 11'h002, 1'b0},
        '{1'b0, 11'h400, 11'h005, 1'b1},
        '{1'b0, 11'h003, 11'h401, 1'b1},
        '{1'b0, 11'h000, 11'h000, 1'b0}
    };

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic ras_n = 1'b1, cas_n = 1'b1, we_n = 1'b1, din = 1'b0;
    logic [10:0] addr = '0;
    logic dout, dout_en, test_active, ref_busy;
    logic [9:0] ref_row;

    int checks = 0;
    int errors = 0;
    logic [9:0] exp_ctr = '0;
    bit done = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    dram_cycle_ctrl uut (
        .clk(clk), .rst_n(rst_n), .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n),
        .addr(addr), .din(din), .dout(dout), .dout_en(dout_en),
        .test_active(test_active), .ref_row(ref_row), .ref_busy(ref_busy)
    );

    task automatic step();
        @(negedge clk);
    endtask

    task automatic check(string tag, logic [15:0] act, logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic do_read(logic [10:0] r, logic [10:0] c, logic e, string tag);
        ras_n = 1'b0; addr = r; step();
        addr = c; cas_n = 1'b0; step();
        check({tag, " R2 dout_en"}, 16'(dout_en), 16'd1);
        check({tag, " R2 dout"}, 16'(dout), 16'(e));
        cas_n = 1'b1; step();
        check({tag, " R4 hold after CAS rise"}, 16'({dout_en, dout}), 16'({1'b1, e}));
        ras_n = 1'b1; step();
        check({tag, " R5 off when both high"}, 16'(dout_en), 16'd0);
    endtask

    task automatic do_write(logic [10:0] r, logic [10:0] c, logic d, string tag);
        ras_n = 1'b0; addr = r; step();
        we_n = 1'b0; din = d; addr = c; step();
        cas_n = 1'b0; step();
        check({tag, " R3 early write hiz"}, 16'(dout_en), 16'd0);
        cas_n = 1'b1; we_n = 1'b1; step();
        check({tag, " R3 hiz after CAS rise"}, 16'(dout_en), 16'd0);
        ras_n = 1'b1; step();
    endtask

    task automatic do_cbr(bit test_set, bit verify);
        cas_n = 1'b0; we_n = test_set ? 1'b0 : 1'b1; step();
        ras_n = 1'b0; addr = 11'h3FF; step();
        if (verify) begin
            check("R6 ref_busy", 16'(ref_busy), 16'd1);
            check("R6/R7 ref_row from counter", 16'(ref_row), 16'(exp_ctr));
            if (test_set) check("R8 test entry", 16'(test_active), 16'd1);
            else          check("R11 CBR clears test", 16'(test_active), 16'd0);
        end
        exp_ctr = exp_ctr + 1'b1;
        ras_n = 1'b1; step();
        cas_n = 1'b1; we_n = 1'b1; step();
    endtask

    task automatic do_ras_only(logic [10:0] r);
        ras_n = 1'b0; addr = r; step();
        ras_n = 1'b1; step();
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        repeat (3) step();
        rst_n = 1'b1;
        step();

        // R1 reset state
        check("R1 dout_en", 16'(dout_en), 16'd0);
        check("R1 test_active", 16'(test_active), 16'd0);
        check("R1 ref_busy", 16'(ref_busy), 16'd0);
        check("R1 ref_row", 16'(ref_row), 16'd0);

        // table walk: R2, R3, R1 (cleared cell)
        for (int i = 0; i < NV; i++) begin
            if (VECS[i].is_wr) do_write(VECS[i].row, VECS[i].col, VECS[i].d, "vec");
            else               do_read(VECS[i].row, VECS[i].col, VECS[i].d, "vec");
        end

        // R4 page mode: two columns in one row, then R5 WE fall turns output off
        ras_n = 1'b0; addr = 11'h003; step();
        addr = 11'h401; cas_n = 1'b0; step();
        cas_n = 1'b1; step();
        check("R4 page hold", 16'({dout_en, dout}), 16'h3);
        addr = 11'h000; cas_n = 1'b0; step();
        check("R4 page second column", 16'({dout_en, dout}), 16'h2);
        cas_n = 1'b1; step();
        we_n = 1'b0; step();
        check("R5 WE fall turns off", 16'(dout_en), 16'd0);
        we_n = 1'b1; ras_n = 1'b1; step();

        // R12 hidden refresh: data kept through refresh, off at CAS rise (R5)
        ras_n = 1'b0; addr = 11'h001; step();
        addr = 11'h002; cas_n = 1'b0; step();
        ras_n = 1'b1; step();
        check("R12 driven with RAS high CAS low", 16'({dout_en, dout}), 16'h3);
        ras_n = 1'b0; addr = 11'h155; step();
        check("R12 refresh busy", 16'(ref_busy), 16'd1);
        check("R12 data kept in refresh", 16'({dout_en, dout}), 16'h3);
        check("R12 ref_row", 16'(ref_row), 16'(exp_ctr));
        exp_ctr = exp_ctr + 1'b1;
        ras_n = 1'b1; step();
        check("R5 still on until CAS rise", 16'(dout_en), 16'd1);
        cas_n = 1'b1; step();
        check("R5 off at later CAS rise", 16'(dout_en), 16'd0);

        // R6/R7 plain counter refreshes
        do_cbr(1'b0, 1'b1);
        do_cbr(1'b0, 1'b1);

        // R8/R9 test mode write of a group
        do_cbr(1'b1, 1'b1);
        do_write(11'h001, 11'h004, 1'b1, "R9 test");
        do_ras_only(11'h001);
        check("R11 RAS-only clears test", 16'(test_active), 16'd0);
        do_read(11'h401, 11'h405, 1'b1, "R9 far cell of group");
        do_read(11'h001, 11'h005, 1'b1, "R9 CA0 cell of group");
        do_write(11'h001, 11'h404, 1'b0, "prep mismatch");

        // R10 compare: mismatch then match (all zero)
        do_cbr(1'b1, 1'b1);
        do_read(11'h001, 11'h004, 1'b0, "R10 mismatch");
        do_write(11'h001, 11'h004, 1'b0, "R9 test clear");
        do_read(11'h001, 11'h004, 1'b1, "R10 match");
        do_cbr(1'b0, 1'b1);
        check("R11 after CBR", 16'(test_active), 16'd0);

        // R7 wrap
        while (exp_ctr != 10'd1023) do_cbr(1'b0, 1'b0);
        do_cbr(1'b0, 1'b1);
        check("R7 wrap expected model", 16'(exp_ctr), 16'd0);
        do_cbr(1'b0, 1'b1);

        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule